// File: doc/BRIEF.md
# System Exception Control and Status Register Block

This block keeps the software-visible state of a processor core's system exceptions. The exceptions covered are the non-maskable interrupt, memory-management fault, bus fault, usage fault, supervisor call, debug monitor, pendable service request and periodic tick. For each one the block holds a pending flag and an active flag. It also holds three fault enables, the vector table base and twelve 8-bit handler priorities. Software reaches all of this through a 32-bit register port that is addressed by byte offset.

An external prioritiser sits next to the block. It supplies the vector number of the active exception, the highest pending vector, an "any external line pending" flag and a "return to base level" flag. These values appear live in the control/state word. The prioritiser also drives hardware masks indexed by exception number: one raises pending, one moves an exception from pending to active, and one retires an active exception. The block sends back one-cycle pulses for every software set or clear of a pending flag, together with a one-cycle system-reset request.

The port is run by a two-state machine. In ST_IDLE, req_ready is high. A request with req_valid takes the ACCEPT transition to ST_RESP, and any write is committed on that same edge. ST_RESP lasts exactly one cycle and presents rsp_valid, rsp_rdata and rsp_err. It then takes the RETIRE transition back to ST_IDLE unconditionally.

Top module: `exc_sysctl_regs`

## Requirements
- R1: A request is accepted only in ST_IDLE (req_ready=1). In the next cycle rsp_valid is 1 for exactly one cycle and req_ready is 0. After that the block is back in ST_IDLE.
- R2: A read of offset 0x004 returns NUM_LINES/32-1, which is 2 for the default of 96 lines.
- R3: A read of offset 0xD04 returns the following fields. Bits [8:0] hold the active vector and bit 11 holds the return-to-base flag. Bits [20:12] hold the pending vector and bit 22 holds the external-pending flag. Bit 26 is tick pending (exception 15), bit 28 is service-request pending (exception 14) and bit 31 is NMI pending (exception 2). All other bits read 0. Writing 1 to bit 31 makes NMI pending.
- R4: In a write to 0xD04, bit 28 sets service-request pending, and bit 27 clears it only when bit 28 is 0. Bits 26 and 25 set and clear tick pending in the same way. Each software set or clear pulses sw_set_o or sw_clr_o at the bit of that exception number, in the response cycle.
- R5: A write to offset 0xD08 stores the data with bits [6:0] forced to 0. The result is seen on vec_base_o and on read.
- R6: A write to offset 0xD0C whose bits [31:16] equal 0x05FA and which has bit 0 or bit 2 set pulses sysreset_req_o for one cycle, in the response cycle. Without the key the write has no effect. A read of 0xD0C returns 0x0FA05000.
- R7: Offsets 0xD18, 0xD1C and 0xD20 each hold four priority bytes, for exceptions 4-7, 8-11 and 12-15 in turn, with the lowest byte for the lowest number. A write replaces all four bytes. prio_o byte k is the priority of exception 4+k.
- R8: A read of offset 0xD24 returns the active flags of exceptions 4, 5, 6, 11, 12, 14 and 15 at bits 0, 1, 3, 7, 8, 10 and 11. It returns the pending flags of exceptions 6, 4, 5 and 11 at bits 12-15, and the fault enables (mem, bus, usage) at bits 16-18. A write changes only the three enables.
- R9: Pending flags exist for exceptions 2, 4, 5, 6, 11, 14 and 15, and active flags exist for 4, 5, 6, 11, 12, 14 and 15. A bit of hw_pend_set sets the pending flag. A bit of hw_enter clears the pending flag and sets the active flag, and hw_pend_set wins in the same cycle. A bit of hw_exit clears the active flag.
- R10: An access to any other offset, misaligned offsets included, reads 0 and gives rsp_err=1 in its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block can accept a request (ST_IDLE) |
| rsp_valid | output | 1 | Response cycle (ST_RESP) |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| rsp_err | output | 1 | Unimplemented offset |
| prio_active_vec | input | VEC_W | Active vector number from prioritiser |
| prio_pending_vec | input | VEC_W | Highest pending vector from prioritiser |
| prio_ext_pending | input | 1 | Any external line pending |
| prio_ret_base | input | 1 | Return would reach base level |
| hw_pend_set | input | 16 | Hardware pending set, by exception number |
| hw_enter | input | 16 | Exception taken: pending to active |
| hw_exit | input | 16 | Exception retired: clear active |
| pend_o | output | 16 | Pending flags by exception number |
| active_o | output | 16 | Active flags by exception number |
| fault_en_o | output | 3 | Fault enables {usage, bus, mem} |
| vec_base_o | output | 32 | Vector table base |
| prio_o | output | 96 | Priority bytes of exceptions 4..15 |
| sw_set_o | output | 16 | Software pending-set pulses |
| sw_clr_o | output | 16 | Software pending-clear pulses |
| sysreset_req_o | output | 1 | System reset request pulse |

## Verification
All state is visible at the ports. The pending, active, enable, base and priority registers drive outputs directly, so a wrong update is visible one cycle after the edge that made it, during the response cycle of the access that caused it. Faults in the read path, such as a field at the wrong position in the control/state or handler word, appear only when that word is read. The bench therefore reads these words back at random after mixed hardware events and writes. A stuck state machine shows up in the next cycle as a missing or doubled rsp_valid.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_CTRL_STATE,
        SEL_VEC_BASE,
        SEL_RESET_CTL,
        SEL_PRIO0,
        SEL_PRIO1,
        SEL_PRIO2,
        SEL_HANDLER
    } reg_sel_e;

    localparam logic [31:0] OFF_TYPE       = 32'h0000_0004;
    localparam logic [31:0] OFF_CTRL_STATE = 32'h0000_0D04;
    localparam logic [31:0] OFF_VEC_BASE   = 32'h0000_0D08;
    localparam logic [31:0] OFF_RESET_CTL  = 32'h0000_0D0C;
    localparam logic [31:0] OFF_PRIO0      = 32'h0000_0D18;
    localparam logic [31:0] OFF_PRIO1      = 32'h0000_0D1C;
    localparam logic [31:0] OFF_PRIO2      = 32'h0000_0D20;
    localparam logic [31:0] OFF_HANDLER    = 32'h0000_0D24;

    localparam int EXC_NMI   = 2;
    localparam int EXC_MEM   = 4;
    localparam int EXC_BUS   = 5;
    localparam int EXC_USAGE = 6;
    localparam int EXC_SVC   = 11;
    localparam int EXC_DEBUG = 12;
    localparam int EXC_SVREQ = 14;
    localparam int EXC_TICK  = 15;

    localparam logic [15:0] PEND_MASK = 16'hC874;
    localparam logic [15:0] ACT_MASK  = 16'hD870;

    localparam logic [15:0] RESET_KEY      = 16'h05FA;
    localparam logic [31:0] RESET_CTL_READ = 32'h0FA0_5000;
    localparam logic [31:0] VEC_BASE_MASK  = 32'hFFFF_FF80;

endpackage

// File: rtl/exc_addr_decode.sv
module exc_addr_decode
    import exc_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    logic [31:0] addr_ext;

    always_comb begin
        addr_ext = 32'(addr);
        unique case (addr_ext)
            OFF_TYPE:       sel = SEL_TYPE;
            OFF_CTRL_STATE: sel = SEL_CTRL_STATE;
            OFF_VEC_BASE:   sel = SEL_VEC_BASE;
            OFF_RESET_CTL:  sel = SEL_RESET_CTL;
            OFF_PRIO0:      sel = SEL_PRIO0;
            OFF_PRIO1:      sel = SEL_PRIO1;
            OFF_PRIO2:      sel = SEL_PRIO2;
            OFF_HANDLER:    sel = SEL_HANDLER;
            default:        sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/exc_prio_bank.sv
module exc_prio_bank #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WORDS-1:0]        wr_en,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_WORDS*WORD_W-1:0] words_o
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en[w]) begin
                word_q <= wdata;
            end
        end

        assign words_o[w*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] sw_set,
    input  logic [15:0] sw_clr,
    input  logic [15:0] hw_set,
    input  logic [15:0] hw_enter,
    input  logic [15:0] hw_exit,
    input  logic        en_wr,
    input  logic [2:0]  en_wdata,
    output logic [15:0] pend_o,
    output logic [15:0] act_o,
    output logic [2:0]  en_o
);
    logic [15:0] pend_q, act_q, pend_d, act_d;
    logic [2:0]  en_q;

    always_comb begin
        pend_d = pend_q & ~hw_enter & ~sw_clr;
        pend_d = (pend_d | hw_set | sw_set) & PEND_MASK;
        act_d  = ((act_q & ~hw_exit) | hw_enter) & ACT_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            act_q  <= act_d;
            if (en_wr) begin
                en_q <= en_wdata;
            end
        end
    end

    assign pend_o = pend_q;
    assign act_o  = act_q;
    assign en_o   = en_q;
endmodule

// File: rtl/exc_sysctl_regs.sv
module exc_sysctl_regs
    import exc_regs_pkg::*;
#(
    parameter int NUM_LINES = 96,
    parameter int ADDR_W    = 12,
    parameter int VEC_W     = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                rsp_err,
    input  logic [VEC_W-1:0]    prio_active_vec,
    input  logic [VEC_W-1:0]    prio_pending_vec,
    input  logic                prio_ext_pending,
    input  logic                prio_ret_base,
    input  logic [15:0]         hw_pend_set,
    input  logic [15:0]         hw_enter,
    input  logic [15:0]         hw_exit,
    output logic [15:0]         pend_o,
    output logic [15:0]         active_o,
    output logic [2:0]          fault_en_o,
    output logic [31:0]         vec_base_o,
    output logic [95:0]         prio_o,
    output logic [15:0]         sw_set_o,
    output logic [15:0]         sw_clr_o,
    output logic                sysreset_req_o
);
    localparam int          PRIO_WORDS = 3;
    localparam logic [31:0] TYPE_VALUE = 32'(NUM_LINES / 32 - 1);
    localparam int          PVEC_LSB   = 12;

    port_state_e state_q, state_d;
    reg_sel_e    sel;
    logic        accept, wr;
    logic [15:0] sw_set_c, sw_clr_c;
    logic [31:0] vec_base_q, rdata_c, ctrl_word, handler_word;
    logic [PRIO_WORDS-1:0] prio_wr;
    logic        reset_hit;

    exc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign wr     = accept && req_write;

    // state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;   // ACCEPT
            ST_RESP: state_d = ST_IDLE;                  // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // software set/clear of pending flags, set wins over clear
    always_comb begin
        sw_set_c = '0;
        sw_clr_c = '0;
        if (wr && sel == SEL_CTRL_STATE) begin
            sw_set_c[EXC_NMI]   = req_wdata[31];
            sw_set_c[EXC_SVREQ] = req_wdata[28];
            sw_clr_c[EXC_SVREQ] = req_wdata[27] && !req_wdata[28];
            sw_set_c[EXC_TICK]  = req_wdata[26];
            sw_clr_c[EXC_TICK]  = req_wdata[25] && !req_wdata[26];
        end
    end

    exc_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_set   (sw_set_c),
        .sw_clr   (sw_clr_c),
        .hw_set   (hw_pend_set),
        .hw_enter (hw_enter),
        .hw_exit  (hw_exit),
        .en_wr    (wr && sel == SEL_HANDLER),
        .en_wdata (req_wdata[18:16]),
        .pend_o   (pend_o),
        .act_o    (active_o),
        .en_o     (fault_en_o)
    );

    assign prio_wr = {wr && sel == SEL_PRIO2, wr && sel == SEL_PRIO1, wr && sel == SEL_PRIO0};

    exc_prio_bank #(.NUM_WORDS(PRIO_WORDS), .WORD_W(32)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prio_wr),
        .wdata   (req_wdata),
        .words_o (prio_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base_q <= '0;
        end else if (wr && sel == SEL_VEC_BASE) begin
            vec_base_q <= req_wdata & VEC_BASE_MASK;
        end
    end
    assign vec_base_o = vec_base_q;

    assign reset_hit = wr && sel == SEL_RESET_CTL && req_wdata[31:16] == RESET_KEY
                       && (req_wdata[0] || req_wdata[2]);

    // packed read views
    always_comb begin
        ctrl_word = '0;
        ctrl_word[VEC_W-1:0] = prio_active_vec;
        ctrl_word[11] = prio_ret_base;
        ctrl_word[PVEC_LSB +: VEC_W] = prio_pending_vec;
        ctrl_word[22] = prio_ext_pending;
        ctrl_word[26] = pend_o[EXC_TICK];
        ctrl_word[28] = pend_o[EXC_SVREQ];
        ctrl_word[31] = pend_o[EXC_NMI];

        handler_word = '0;
        handler_word[0]  = active_o[EXC_MEM];
        handler_word[1]  = active_o[EXC_BUS];
        handler_word[3]  = active_o[EXC_USAGE];
        handler_word[7]  = active_o[EXC_SVC];
        handler_word[8]  = active_o[EXC_DEBUG];
        handler_word[10] = active_o[EXC_SVREQ];
        handler_word[11] = active_o[EXC_TICK];
        handler_word[12] = pend_o[EXC_USAGE];
        handler_word[13] = pend_o[EXC_MEM];
        handler_word[14] = pend_o[EXC_BUS];
        handler_word[15] = pend_o[EXC_SVC];
        handler_word[18:16] = fault_en_o;
    end

    always_comb begin
        unique case (sel)
            SEL_TYPE:       rdata_c = TYPE_VALUE;
            SEL_CTRL_STATE: rdata_c = ctrl_word;
            SEL_VEC_BASE:   rdata_c = vec_base_q;
            SEL_RESET_CTL:  rdata_c = RESET_CTL_READ;
            SEL_PRIO0:      rdata_c = prio_o[31:0];
            SEL_PRIO1:      rdata_c = prio_o[63:32];
            SEL_PRIO2:      rdata_c = prio_o[95:64];
            SEL_HANDLER:    rdata_c = handler_word;
            default:        rdata_c = '0;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata      <= '0;
            rsp_err        <= 1'b0;
            sw_set_o       <= '0;
            sw_clr_o       <= '0;
            sysreset_req_o <= 1'b0;
        end else begin
            rsp_rdata      <= (accept && !req_write) ? rdata_c : '0;
            rsp_err        <= accept && sel == SEL_NONE;
            sw_set_o       <= sw_set_c;
            sw_clr_o       <= sw_clr_c;
            sysreset_req_o <= reset_hit;
        end
    end
endmodule

// File: rtl/exc_sysctl_regs_chk.sv
module exc_sysctl_regs_chk
    import exc_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [15:0]       hw_pend_set,
    input logic [15:0]       pend_o,
    input logic [31:0]       vec_base_o,
    input logic [15:0]       sw_set_o,
    input logic [15:0]       sw_clr_o,
    input logic              sysreset_req_o
);
    logic        acc_wr;
    logic [31:0] a32;
    assign acc_wr = req_valid && req_ready && req_write;
    assign a32    = 32'(req_addr);

    p_accept_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    p_single_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_nmi_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && a32 == OFF_CTRL_STATE && req_wdata[31]) |=> pend_o[EXC_NMI]);

    p_events_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set_o & sw_clr_o) == 16'h0);

    p_svreq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && a32 == OFF_CTRL_STATE && !req_wdata[28] && req_wdata[27]
         && !hw_pend_set[EXC_SVREQ]) |=> !pend_o[EXC_SVREQ]);

    p_vec_base_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && a32 == OFF_VEC_BASE) |=> vec_base_o == ($past(req_wdata) & VEC_BASE_MASK));

    p_reset_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && a32 == OFF_RESET_CTL && req_wdata[31:16] != RESET_KEY) |=> !sysreset_req_o);

    p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(hw_pend_set) & PEND_MASK) == ($past(hw_pend_set) & PEND_MASK)));

    p_pend_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~PEND_MASK) == 16'h0);

    p_err_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
endmodule

bind exc_sysctl_regs exc_sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/exc_sysctl_regs_tb.sv
module exc_sysctl_regs_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_write = 0, rsp_valid, rsp_err, req_ready;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0, rsp_rdata, vec_base_o;
    logic [8:0]  avec = '0, pvec = '0;
    logic        ext_p = 0, ret_b = 0, sysreset_req_o;
    logic [15:0] hw_set = '0, hw_ent = '0, hw_ext = '0;
    logic [15:0] pend_o, active_o, sw_set_o, sw_clr_o;
    logic [2:0]  fault_en_o;
    logic [95:0] prio_o;

    exc_sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .prio_active_vec(avec), .prio_pending_vec(pvec), .prio_ext_pending(ext_p),
        .prio_ret_base(ret_b), .hw_pend_set(hw_set), .hw_enter(hw_ent), .hw_exit(hw_ext),
        .pend_o(pend_o), .active_o(active_o), .fault_en_o(fault_en_o),
        .vec_base_o(vec_base_o), .prio_o(prio_o), .sw_set_o(sw_set_o),
        .sw_clr_o(sw_clr_o), .sysreset_req_o(sysreset_req_o)
    );

    localparam logic [15:0] PM = 16'hC874;
    localparam logic [15:0] AM = 16'hD870;

    int nvec = 0, nfail = 0;
    bit done = 0;
    logic [15:0] m_pend = '0, m_act = '0;
    logic [2:0]  m_en = '0;
    logic [31:0] m_vbase = '0;
    logic [95:0] m_prio = '0;

    task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [11:0] a);
        logic [31:0] v = '0;
        case (a)
            12'h004: v = 32'd2;
            12'hD04: begin
                v[8:0] = avec; v[11] = ret_b; v[20:12] = pvec; v[22] = ext_p;
                v[26] = m_pend[15]; v[28] = m_pend[14]; v[31] = m_pend[2];
            end
            12'hD08: v = m_vbase;
            12'hD0C: v = 32'h0FA05000;
            12'hD18: v = m_prio[31:0];
            12'hD1C: v = m_prio[63:32];
            12'hD20: v = m_prio[95:64];
            12'hD24: begin
                v[0] = m_act[4]; v[1] = m_act[5]; v[3] = m_act[6]; v[7] = m_act[11];
                v[8] = m_act[12]; v[10] = m_act[14]; v[11] = m_act[15];
                v[12] = m_pend[6]; v[13] = m_pend[4]; v[14] = m_pend[5]; v[15] = m_pend[11];
                v[18:16] = m_en;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic bit is_valid(logic [11:0] a);
        return a inside {12'h004, 12'hD04, 12'hD08, 12'hD0C, 12'hD18, 12'hD1C, 12'hD20, 12'hD24};
    endfunction

    task automatic check_state(string tag);
        check({tag, " R9 pend"}, 96'(pend_o), 96'(m_pend));
        check({tag, " R9 active"}, 96'(active_o), 96'(m_act));
        check({tag, " R8 enables"}, 96'(fault_en_o), 96'(m_en));
        check({tag, " R5 base"}, 96'(vec_base_o), 96'(m_vbase));
        check({tag, " R7 prio"}, prio_o, m_prio);
    endtask

    task automatic access(bit wr, logic [11:0] a, logic [31:0] wd, string tag);
        logic [31:0] e_rd;
        logic [15:0] e_set, e_clr;
        bit e_rst;
        e_rd = wr ? 32'h0 : exp_read(a);
        e_set = '0; e_clr = '0;
        if (wr && a == 12'hD04) begin
            e_set[2] = wd[31]; e_set[14] = wd[28]; e_set[15] = wd[26];
            e_clr[14] = wd[27] & ~wd[28]; e_clr[15] = wd[25] & ~wd[26];
        end
        e_rst = wr && a == 12'hD0C && wd[31:16] == 16'h05FA && (wd[0] || wd[2]);
        check({tag, " R1 ready idle"}, 96'(req_ready), 96'(1));
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        if (wr) begin
            case (a)
                12'hD04: m_pend = (m_pend | e_set) & ~e_clr;
                12'hD08: m_vbase = wd & 32'hFFFFFF80;
                12'hD18: m_prio[31:0] = wd;
                12'hD1C: m_prio[63:32] = wd;
                12'hD20: m_prio[95:64] = wd;
                12'hD24: m_en = wd[18:16];
                default: ;
            endcase
        end
        check({tag, " R1 rsp_valid"}, 96'(rsp_valid), 96'(1));
        check({tag, " R1 ready low"}, 96'(req_ready), 96'(0));
        check({tag, " R3 rdata"}, 96'(rsp_rdata), 96'(e_rd));
        check({tag, " R10 err"}, 96'(rsp_err), 96'(!is_valid(a)));
        check({tag, " R4 set pulse"}, 96'(sw_set_o), 96'(e_set));
        check({tag, " R4 clr pulse"}, 96'(sw_clr_o), 96'(e_clr));
        check({tag, " R6 reset req"}, 96'(sysreset_req_o), 96'(e_rst));
        check_state(tag);
        @(negedge clk);
        check({tag, " R1 single rsp"}, 96'(rsp_valid), 96'(0));
        check({tag, " R6 pulse once"}, 96'(sysreset_req_o), 96'(0));
    endtask

    task automatic hw_event(logic [15:0] s, logic [15:0] en, logic [15:0] ex, string tag);
        hw_set = s; hw_ent = en; hw_ext = ex;
        @(negedge clk);
        hw_set = '0; hw_ent = '0; hw_ext = '0;
        m_pend = ((m_pend & ~en) | s) & PM;
        m_act = ((m_act & ~ex) | en) & AM;
        check_state(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [11:0] addrs [8] = '{12'h004, 12'hD04, 12'hD08, 12'hD0C, 12'hD18, 12'hD1C, 12'hD20, 12'hD24};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check_state("reset");
        check("R1 reset ready", 96'(req_ready), 96'(1));
        // directed corner cases
        access(0, 12'h004, 0, "R2 type word");
        access(1, 12'hD04, 32'h9400_0000, "R3 nmi+svreq+tick set");
        access(1, 12'hD04, 32'h1A00_0000, "R4 set beats clear");
        access(1, 12'hD04, 32'h0A00_0000, "R4 clear both");
        access(0, 12'hD04, 0, "R3 readback");
        access(1, 12'hD08, 32'hFFFF_FFFF, "R5 base align");
        access(0, 12'hD08, 0, "R5 base read");
        access(1, 12'hD0C, 32'h05FB_0005, "R6 wrong key");
        access(1, 12'hD0C, 32'h05FA_0004, "R6 key bit2");
        access(1, 12'hD0C, 32'h05FA_0002, "R6 key no reset bit");
        access(0, 12'hD0C, 0, "R6 readback");
        access(1, 12'hD1C, 32'hA1B2_C3D4, "R7 prio word1");
        access(1, 12'hD24, 32'hFFFF_FFFF, "R8 only enables");
        access(0, 12'hD24, 0, "R8 handler read");
        access(0, 12'hD05, 0, "R10 misaligned");
        access(1, 12'h100, 32'hFFFF_FFFF, "R10 hole write");
        hw_event(16'hFFFF, '0, '0, "R9 set all");
        hw_event(16'h0010, 16'hFFFF, '0, "R9 enter, set wins");
        access(0, 12'hD24, 0, "R8 after enter");
        hw_event('0, '0, 16'h0070, "R9 exit faults");
        // constrained random
        for (int i = 0; i < 1500; i++) begin
            avec = 9'($urandom); pvec = 9'($urandom);
            ext_p = 1'($urandom); ret_b = 1'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                hw_event(16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom),
                         16'($urandom), "R9 random hw");
            end else begin
                logic [11:0] a;
                logic [31:0] d;
                a = ($urandom_range(0, 9) == 0) ? 12'($urandom) : addrs[$urandom_range(0, 7)];
                d = $urandom;
                if (a == 12'hD0C && $urandom_range(0, 1) == 1) d[31:16] = 16'h05FA;
                access(1'($urandom), a, d, "R3 random access");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule